// File: doc/BRIEF.md
# I2C Slave Front End for a Word-Organised Non-Volatile Store

This block is an I2C slave that gives a host byte-addressed access to a small non-volatile store organised as 16-bit words. The seven-bit device address carries a fixed six-bit tag followed by the top bit of a nine-bit memory address. The second byte of a write transaction supplies the lower eight address bits. The slave keeps this address as a pointer. Reads need no address byte: they start from the stored pointer, shift each byte out most significant bit first, and advance the pointer after every byte.

Writes must hold exactly one or two whole words. The block collects the data bytes, clears the low address bits that a word or a double word ignores, and checks length, range and the protected calibration bytes. A passing write is committed to the store only when the STOP arrives. The store then stays busy for a fixed number of cycles, and during that time the slave answers no transaction. The SCL and SDA inputs are already synchronised to the system clock. The SDA output is an open-drain pull-down enable.

Top module: `nvmi_front`

## Requirements
- R1: After reset, SDA is released (sda_oe = 0) and every store byte at index i holds (i mod 256) XOR 0xA5.
- R2: A device byte whose upper six bits are 110111 is acknowledged when the store is idle. Bit 1 of that byte is the memory address bit 8 and bit 0 is read (1) or write (0). A device byte with any other upper bits, such as 0xA0, is not acknowledged.
- R3: In a write transaction the second byte is acknowledged and loads the pointer with {address bit 8, second byte}. This happens even when the write is later rejected. The pointer is not advanced by the data bytes, so a following read starts at the header address.
- R4: A read starts at the stored pointer and ignores address bit 8 in the device byte. It sends bit 7 first and advances the pointer by one after each byte. The master's acknowledge continues the read and a not-acknowledge ends it.
- R5: Reading at or beyond byte MEM_BYTES (320) returns 0xFF, and the pointer stays at that limit.
- R6: Exactly 2 data bytes write one word at the header address with bit 0 cleared. The first data byte goes to the lower byte address.
- R7: Exactly 4 data bytes write two words at the header address with bits 1 and 0 cleared, in byte order.
- R8: A write with 0, 1, 3 or 5 or more data bytes changes no store byte and starts no busy time. Every data byte is still acknowledged.
- R9: A word write is suppressed when it touches a calibration byte (indices CAL_BASE to CAL_BASE+CAL_BYTES-1, default 0 to 7) or reaches index 320 or above. Calibration bytes stay readable.
- R10: A write is committed only on STOP. A repeated START after data bytes drops them. A read after that repeated START continues from the address set by the write header.
- R11: After a commit the slave does not acknowledge its device address for WR_CYCLES cycles, the same for one and two words, and acknowledges again afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronised SCL level |
| sda_i | input | 1 | Synchronised SDA level (wired bus value) |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
The slave changes sda_oe one clock after it sees SCL fall, and it never changes it while SCL stays high. The bench therefore holds every SCL phase for four clocks and samples SDA two clocks into the high phase, well clear of both edges. Busy time starts one clock after the STOP is detected and lasts WR_CYCLES cycles. A probe sent straight after a committed write must be refused, and a probe sent WR_CYCLES+40 cycles later must be accepted. Store contents are read back over the bus and compared, byte for byte, with a bench-side model that the driver updates under the write rules.

// File: rtl/nvmi_pkg.sv
package nvmi_pkg;

  localparam int ADDR_W     = 9;
  localparam int WBUF_BYTES = 4;
  localparam logic [5:0] DEV_TAG = 6'b110111;

  typedef enum logic [3:0] {
    S_IDLE, S_DEV, S_DACK, S_ADDR, S_AACK,
    S_WDAT, S_WACK, S_TX, S_MACK, S_SKIP
  } nvmi_st_e;

  // first byte of the word (or double word) a write of this size lands on
  function automatic logic [ADDR_W-1:0] word_base(input logic [ADDR_W-1:0] a,
                                                  input logic four);
    return four ? {a[ADDR_W-1:2], 2'b00} : {a[ADDR_W-1:1], 1'b0};
  endfunction

  // only exactly one or two whole words may be committed
  function automatic logic len_ok(input logic [2:0] nb);
    return (nb == 3'd2) || (nb == 3'd4);
  endfunction

  // span lies inside the store and clear of the calibration bytes
  function automatic logic span_ok(input logic [ADDR_W-1:0] base, input logic four,
                                   input int mem_bytes, input int cal_base,
                                   input int cal_bytes);
    int lo;
    int hi;
    lo = int'(base);
    hi = lo + (four ? 3 : 1);
    return (hi < mem_bytes) && ((hi < cal_base) || (lo >= cal_base + cal_bytes));
  endfunction

  function automatic logic [7:0] seed_byte(input int idx);
    return 8'(idx) ^ 8'hA5;
  endfunction

endpackage

// File: rtl/nvmi_linecond.sv
module nvmi_linecond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise  = scl_i & ~scl_q;
  assign scl_fall  = ~scl_i & scl_q;
  assign start_det = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_det  = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/nvmi_store.sv
module nvmi_store
  import nvmi_pkg::*;
#(
  parameter int MEM_BYTES = 320,
  parameter int WR_CYCLES = 500000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req,
  input  logic [ADDR_W-1:0] wr_base,
  input  logic              wr_four,
  input  logic [8*WBUF_BYTES-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              busy
);
  localparam int CW = $clog2(WR_CYCLES + 1);
  localparam logic [CW-1:0] CNT_LOAD = CW'(WR_CYCLES);

  logic [7:0]    mem [MEM_BYTES];
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= seed_byte(i);
    end else if (wr_req) begin
      for (int k = 0; k < WBUF_BYTES; k++)
        if (k < 2 || wr_four) mem[wr_base + ADDR_W'(k)] <= wr_data[8*k +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (wr_req)           cnt <= CNT_LOAD;
    else if (cnt != '0)        cnt <= cnt - CW'(1);
  end

  assign busy    = (cnt != '0);
  assign rd_data = (int'(rd_addr) < MEM_BYTES) ? mem[rd_addr] : 8'hFF;
endmodule

// File: rtl/nvmi_proto.sv
module nvmi_proto
  import nvmi_pkg::*;
#(
  parameter int MEM_BYTES = 320,
  parameter int CAL_BASE  = 0,
  parameter int CAL_BYTES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              sda_in,
  input  logic              busy,
  input  logic [7:0]        rd_data,
  output logic              sda_oe,
  output logic [ADDR_W-1:0] ptr,
  output logic              ptr_ld,
  output logic              ptr_inc,
  output logic              wr_req,
  output logic [ADDR_W-1:0] wr_base,
  output logic              wr_four,
  output logic [8*WBUF_BYTES-1:0] wr_data
);
  nvmi_st_e          st;
  logic [7:0]        sh, txb;
  logic [3:0]        cnt;
  logic              rw, mbit, more, wr_open, oe;
  logic [2:0]        nb;
  logic [8*WBUF_BYTES-1:0] wbuf;
  logic [ADDR_W-1:0] ptr_q;

  logic quiet, byte_done, dev_hit, shifting;

  assign quiet     = !start_det && !stop_det;
  assign byte_done = scl_fall && (cnt == 4'd8);
  assign dev_hit   = (sh[7:2] == DEV_TAG);
  assign shifting  = (st == S_DEV) || (st == S_ADDR) || (st == S_WDAT);
  assign ptr_ld    = quiet && (st == S_ADDR) && byte_done;
  assign ptr_inc   = quiet && (st == S_TX) && byte_done && (int'(ptr_q) < MEM_BYTES);
  assign wr_four   = (nb == 3'd4);
  assign wr_base   = word_base(ptr_q, wr_four);
  assign wr_req    = stop_det && wr_open && len_ok(nb) &&
                     span_ok(wr_base, wr_four, MEM_BYTES, CAL_BASE, CAL_BYTES);
  assign wr_data   = wbuf;
  assign sda_oe    = oe;
  assign ptr       = ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      sh      <= '0;
      txb     <= '0;
      cnt     <= '0;
      rw      <= 1'b0;
      mbit    <= 1'b0;
      more    <= 1'b0;
      wr_open <= 1'b0;
      oe      <= 1'b0;
      nb      <= '0;
      wbuf    <= '0;
      ptr_q   <= '0;
    end else if (stop_det) begin
      st      <= S_IDLE;
      oe      <= 1'b0;
      wr_open <= 1'b0;
    end else if (start_det) begin
      st      <= S_DEV;
      cnt     <= '0;
      oe      <= 1'b0;
      wr_open <= 1'b0;
    end else begin
      if (scl_rise && shifting) begin
        sh  <= {sh[6:0], sda_in};
        cnt <= cnt + 4'd1;
      end
      case (st)
        S_DEV: if (byte_done) begin
          if (dev_hit && !busy) begin
            oe   <= 1'b1;
            rw   <= sh[0];
            mbit <= sh[1];
            st   <= S_DACK;
          end else begin
            st <= S_SKIP;
          end
        end
        S_DACK: if (scl_fall) begin
          if (rw) begin
            oe  <= ~rd_data[7];
            txb <= rd_data;
            cnt <= 4'd1;
            st  <= S_TX;
          end else begin
            oe  <= 1'b0;
            cnt <= 4'd0;
            st  <= S_ADDR;
          end
        end
        S_ADDR: if (byte_done) begin
          ptr_q   <= {mbit, sh};
          oe      <= 1'b1;
          nb      <= '0;
          wr_open <= 1'b1;
          st      <= S_AACK;
        end
        S_AACK, S_WACK: if (scl_fall) begin
          oe  <= 1'b0;
          cnt <= 4'd0;
          st  <= S_WDAT;
        end
        S_WDAT: if (byte_done) begin
          if (nb < 3'd4) wbuf[{nb[1:0], 3'b000} +: 8] <= sh;
          if (nb != 3'd5) nb <= nb + 3'd1;
          oe <= 1'b1;
          st <= S_WACK;
        end
        S_TX: if (scl_fall) begin
          if (cnt == 4'd8) begin
            oe <= 1'b0;
            if (ptr_inc) ptr_q <= ptr_q + ADDR_W'(1);
            st <= S_MACK;
          end else begin
            oe  <= ~txb[~cnt[2:0]];
            cnt <= cnt + 4'd1;
          end
        end
        S_MACK: begin
          if (scl_rise) more <= ~sda_in;
          if (scl_fall) begin
            if (more) begin
              oe  <= ~rd_data[7];
              txb <= rd_data;
              cnt <= 4'd1;
              st  <= S_TX;
            end else begin
              oe <= 1'b0;
              st <= S_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/nvmi_front.sv
module nvmi_front
  import nvmi_pkg::*;
#(
  parameter int MEM_BYTES = 320,
  parameter int WR_CYCLES = 500000,
  parameter int CAL_BASE  = 0,
  parameter int CAL_BYTES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  logic              scl_rise, scl_fall, start_det, stop_det;
  logic              busy, wr_req, wr_four, ptr_ld, ptr_inc;
  logic [ADDR_W-1:0] ptr, wr_base;
  logic [8*WBUF_BYTES-1:0] wr_data;
  logic [7:0]        rd_data;

  nvmi_linecond u_line (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  nvmi_proto #(.MEM_BYTES(MEM_BYTES), .CAL_BASE(CAL_BASE), .CAL_BYTES(CAL_BYTES)) u_proto (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .sda_in(sda_i), .busy(busy),
    .rd_data(rd_data), .sda_oe(sda_oe), .ptr(ptr), .ptr_ld(ptr_ld),
    .ptr_inc(ptr_inc), .wr_req(wr_req), .wr_base(wr_base), .wr_four(wr_four),
    .wr_data(wr_data)
  );

  nvmi_store #(.MEM_BYTES(MEM_BYTES), .WR_CYCLES(WR_CYCLES)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_base(wr_base),
    .wr_four(wr_four), .wr_data(wr_data), .rd_addr(ptr), .rd_data(rd_data),
    .busy(busy)
  );
endmodule

// File: rtl/nvmi_front_chk.sv
module nvmi_front_chk
  import nvmi_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              scl_i,
  input logic              sda_oe,
  input logic              busy,
  input logic              wr_req,
  input logic              ptr_ld,
  input logic              ptr_inc,
  input logic [ADDR_W-1:0] ptr
);
  AST_QUIET_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_oe);                                                   // R11
  AST_REQ_ONLY_READY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> !busy);                                                   // R11
  AST_BUSY_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |=> busy);                                                    // R10
  AST_SDA_HELD_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_i && $past(scl_i)) |-> $stable(sda_oe));                        // R4
  AST_PTR_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr != $past(ptr)) |-> $past(ptr_ld || ptr_inc));                   // R3
endmodule

bind nvmi_front nvmi_front_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe), .busy(busy),
  .wr_req(wr_req), .ptr_ld(ptr_ld), .ptr_inc(ptr_inc), .ptr(ptr)
);

// File: tb/nvmi_front_test.sv
module nvmi_front_test;
  localparam int MEMB = 320;
  localparam int WRC  = 400;
  localparam int CALB = 8;
  localparam int Q    = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_oe;
  wire  sda_line = m_sda & ~sda_oe;

  always #5 clk = ~clk;

  nvmi_front #(.MEM_BYTES(MEMB), .WR_CYCLES(WRC), .CAL_BASE(0), .CAL_BYTES(CALB)) uut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [7:0] bm [MEMB];
  int bptr = 0;
  int exp_q[$];
  string tag_q[$];
  int act_q[$];
  logic [7:0] wb [6];

  task automatic wrap();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic hp();
    repeat (Q) @(negedge clk);
  endtask

  task automatic push_exp(input string t, input int v);
    exp_q.push_back(v);
    tag_q.push_back(t);
  endtask

  // monitor: pairs each observed item with the oldest expectation
  always @(negedge clk) begin
    if (act_q.size() > 0 && exp_q.size() > 0) begin
      int a;
      int e;
      string t;
      a = act_q.pop_front();
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_chk++;
      if (a != e) begin
        n_bad++;
        $display("FAIL %s: actual 0x%0h expected 0x%0h", t, a, e);
      end
    end
  end

  task automatic bus_start();
    m_sda = 1'b1; hp();
    m_scl = 1'b1; hp();
    m_sda = 1'b0; hp();
    m_scl = 1'b0; hp();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; hp();
    m_scl = 1'b1; hp();
    m_sda = 1'b1; hp();
  endtask

  task automatic put_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; hp();
      m_scl = 1'b1; hp();
      m_scl = 1'b0; hp();
    end
    m_sda = 1'b1; hp();
    m_scl = 1'b1;
    repeat (2) @(negedge clk);
    act_q.push_back(sda_line == 1'b0 ? 1 : 0);
    repeat (Q - 2) @(negedge clk);
    m_scl = 1'b0; hp();
  endtask

  task automatic get_byte(input bit ack);
    logic [7:0] b;
    for (int i = 7; i >= 0; i--) begin
      m_sda = 1'b1; hp();
      m_scl = 1'b1;
      repeat (2) @(negedge clk);
      b[i] = sda_line;
      repeat (Q - 2) @(negedge clk);
      m_scl = 1'b0; hp();
    end
    act_q.push_back(int'(b));
    m_sda = ack ? 1'b0 : 1'b1; hp();
    m_scl = 1'b1; hp();
    m_scl = 1'b0; hp();
    m_sda = 1'b1;
  endtask

  // bench model of one read byte: value at the pointer, then advance up to the limit
  function automatic int next_rd();
    int v;
    v = (bptr < MEMB) ? int'(bm[bptr]) : 255;
    if (bptr < MEMB) bptr++;
    return v;
  endfunction

  task automatic write_txn(input int a, input int n, output bit cm);
    logic [8:0] av;
    int b;
    int last;
    av = 9'(a);
    push_exp("R2 device ack on write", 1);
    push_exp("R3 address byte ack", 1);
    for (int k = 0; k < n; k++) push_exp("R8 data byte ack", 1);
    bus_start();
    put_byte({6'b110111, av[8], 1'b0});
    put_byte(av[7:0]);
    for (int k = 0; k < n; k++) put_byte(wb[k]);
    bus_stop();
    bptr = a;
    cm = 1'b0;
    b = 0;
    last = 0;
    if (n == 2) begin b = a - (a % 2); last = b + 1; cm = 1'b1; end
    else if (n == 4) begin b = a - (a % 4); last = b + 3; cm = 1'b1; end
    if (cm && (last >= MEMB || b < CALB)) cm = 1'b0;
    if (cm) for (int k = 0; k < n; k++) bm[b + k] = wb[k];
  endtask

  task automatic read_txn(input int n, input bit m, input string t);
    push_exp("R2 device ack on read", 1);
    for (int k = 0; k < n; k++) push_exp(t, next_rd());
    bus_start();
    put_byte({6'b110111, m, 1'b1});
    for (int k = 0; k < n; k++) get_byte(k < n - 1);
    bus_stop();
  endtask

  // write header (plus optional data), repeated START, then a read
  task automatic hdr_rs_read(input int a, input int nd, input int nr, input bit m,
                             input string t);
    logic [8:0] av;
    av = 9'(a);
    push_exp("R2 device ack on write", 1);
    push_exp("R3 address byte ack", 1);
    for (int k = 0; k < nd; k++) push_exp("R10 data ack before Sr", 1);
    bptr = a;
    push_exp("R10 device ack after Sr", 1);
    for (int k = 0; k < nr; k++) push_exp(t, next_rd());
    bus_start();
    put_byte({6'b110111, av[8], 1'b0});
    put_byte(av[7:0]);
    for (int k = 0; k < nd; k++) put_byte(wb[k]);
    bus_start();
    put_byte({6'b110111, m, 1'b1});
    for (int k = 0; k < nr; k++) get_byte(k < nr - 1);
    bus_stop();
  endtask

  task automatic probe(input int e, input string t);
    push_exp(t, e);
    bus_start();
    put_byte({6'b110111, 1'b0, 1'b0});
    bus_stop();
  endtask

  task automatic settle(input bit cm);
    if (cm) begin
      probe(0, "R11 address refused during write time");
      repeat (WRC + 40) @(negedge clk);
      probe(1, "R11 address accepted after write time");
    end else begin
      probe(1, "R8 no write time started");
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual still running expected finished");
    wrap();
  end

  initial begin
    bit cm;
    for (int i = 0; i < MEMB; i++) bm[i] = 8'((i & 255) ^ 165);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    hp();
    n_chk++;
    if (sda_oe !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 reset release: actual %b expected 0", sda_oe);
    end

    // R1 seed contents, calibration bytes readable (R9); header-only write
    write_txn(0, 0, cm); settle(cm);
    read_txn(6, 1'b0, "R1 seed byte");

    // R6 one word, address bit 0 ignored
    wb[0] = 8'hAB; wb[1] = 8'hCD;
    write_txn('h21, 2, cm); settle(cm);
    read_txn(2, 1'b0, "R3 read from header address");
    hdr_rs_read('h20, 0, 3, 1'b0, "R6 one-word write");

    // R7 two words, address bits 1:0 ignored, M bit set
    wb[0] = 8'h11; wb[1] = 8'h22; wb[2] = 8'h33; wb[3] = 8'h44;
    write_txn('h13B, 4, cm); settle(cm);
    hdr_rs_read('h138, 0, 4, 1'b0, "R7 two-word write");
    read_txn(2, 1'b1, "R4 M bit ignored on read");

    // R8 bad lengths
    wb[0] = 8'h5A; wb[1] = 8'h5B; wb[2] = 8'h5C; wb[3] = 8'h5D; wb[4] = 8'h5E;
    write_txn('h40, 3, cm); settle(cm);
    read_txn(4, 1'b0, "R8 three bytes dropped");
    write_txn('h44, 1, cm); settle(cm);
    read_txn(2, 1'b0, "R8 one byte dropped");
    write_txn('h48, 5, cm); settle(cm);
    read_txn(4, 1'b0, "R8 five bytes dropped");

    // R9 calibration and range protection
    wb[0] = 8'h77; wb[1] = 8'h88;
    write_txn('h04, 2, cm); settle(cm);
    read_txn(2, 1'b0, "R9 calibration write suppressed");
    write_txn('h140, 2, cm); settle(cm);
    read_txn(2, 1'b0, "R5 pointer beyond end reads 0xFF");

    // R5 read across the end
    hdr_rs_read('h13E, 0, 4, 1'b1, "R5 read across end");

    // R10 repeated START drops pending data
    wb[0] = 8'h99; wb[1] = 8'h98;
    hdr_rs_read('h60, 2, 2, 1'b0, "R10 data dropped by repeated start");
    probe(1, "R10 no write time after repeated start");

    // R2 foreign device addresses
    push_exp("R2 foreign address 0xA0", 0);
    bus_start(); put_byte(8'hA0); bus_stop();
    push_exp("R2 foreign address 0xD8", 0);
    bus_start(); put_byte(8'hD8); bus_stop();

    while (exp_q.size() > 0) @(negedge clk);
    repeat (5) @(negedge clk);
    wrap();
  end
endmodule